// File: doc/BRIEF.md
# Carrier Detect Qualifier with Release Hold-Off

This block decides whether an in-band carrier is present. Its input is a single-bit activity flag produced by an upstream band filter and level comparator, and that flag may arrive asynchronously. The block synchronises the flag and requires it to stay present, without a break, for a qualification window before it declares a carrier. It then drives an active-low carrier-detect pin and raises a gate that enables the downstream bit-timing recovery.

Once a carrier is declared, short dropouts in activity do not release it. Any sample with activity reloads a hold-off timer. The carrier is dropped only after the timer runs out with no activity at all. The default windows are 8 ms to qualify and 10 ms to hold, counted in cycles of a 3.579545 MHz reference clock.

A power-down input forces the block idle. On wake-up, a carrier must be qualified again from the beginning.

Top module: `cd_qualifier`

## Requirements
- R1: `cd_n` is low exactly when a carrier is declared. `rx_gate` is its complement in every cycle, so it is high only while a carrier is declared.
- R2: After a synchronous reset (`rst_n` low at a clock edge), `cd_n` is 1 and `rx_gate` is 0, whatever `act_in` is.
- R3: A carrier is declared only after QUAL_CYCLES consecutive synchronised samples with activity. A run of activity shorter than that never pulls `cd_n` low.
- R4: A single inactive sample during qualification restarts the count from zero, so a full new run of QUAL_CYCLES samples is needed after it.
- R5: `act_in` passes through a two-flop synchroniser. If `act_in` is first high at clock edge 1 and stays high, `cd_n` is first seen low after edge QUAL_CYCLES+2.
- R6: While a carrier is declared, any active sample reloads the hold-off. A gap of fewer than HOLD_CYCLES inactive samples leaves `cd_n` low for the whole gap.
- R7: The carrier is released, with `cd_n` returning to 1, after exactly HOLD_CYCLES consecutive inactive samples. With activity high on edges 1..L (L ≥ QUAL_CYCLES) and low afterwards, `cd_n` returns to 1 after edge L+HOLD_CYCLES+2.
- R8: While `pwdn` is high, `cd_n` is 1 and `rx_gate` is 0 from the edge after `pwdn` is first sampled high, even with activity present.
- R9: Power-down clears the synchroniser and both counters. After `pwdn` falls, a carrier needs the full latency of R5 again, counted from the first edge with `pwdn` low.
- R10: The defaults are QUAL_CYCLES = 28636 (8 ms) and HOLD_CYCLES = 35795 (10 ms). With the defaults and activity high from edge 1 to edge 28640, `cd_n` falls after edge 28638 and rises after edge 64437.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_in | input | 1 | Activity flag from the band filter and level detector, possibly asynchronous |
| pwdn | input | 1 | Power-down, active high, synchronous to `clk` |
| cd_n | output | 1 | Carrier detect, active low |
| rx_gate | output | 1 | High while a carrier is declared; enables downstream timing recovery |

## Verification
The bench uses short windows and sweeps the length of an isolated activity burst across the qualification threshold. This checks that a burst one sample too short never asserts, and that a long enough burst asserts with exact latency and holds for exactly the hold-off. A one-sample hole is moved through every position of the qualification run to show that each position restarts the count. After a declared carrier, dropout gaps are swept from one sample to beyond the hold-off, which separates a ride-through from a release followed by re-qualification. Power-down is applied during a declared carrier with activity held present, and a run with the default parameters confirms the millisecond-scale windows.

// File: rtl/cdq_pkg.sv
// Shared types for the carrier detect qualifier.
package cdq_pkg;

    // Decision state: no carrier yet, or carrier declared.
    typedef enum logic {
        CDQ_IDLE    = 1'b0,
        CDQ_CARRIER = 1'b1
    } cdq_state_t;

endpackage

// File: rtl/cdq_sync.sv
// Multi-flop synchroniser for the activity flag.
// Assumes: STAGES >= 2; clr empties the chain so stale activity from
// before a power-down cannot leak into a fresh qualification.
module cdq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop of the chain, cleared by reset or clr.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) chain[g] <= 1'b0;
                else if (g == 0)   chain[g] <= d;
                else               chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cdq_qual.sv
// Qualification counter: counts consecutive active samples and flags
// the sample that completes QUAL_CYCLES of them.
// Assumes: clr is held while a carrier is declared or in power-down.
module cdq_qual #(
    parameter int QUAL_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic act,
    output logic done
);
    localparam int QW = $clog2(QUAL_CYCLES + 1);
    localparam logic [QW-1:0] LAST = QW'(QUAL_CYCLES - 1);

    logic [QW-1:0] cnt;

    // Purpose: completion when the last needed sample is active.
    assign done = !clr && act && (cnt == LAST);

    // Purpose: advance on activity, restart on a gap or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (!act)      cnt <= '0;
        else if (done)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // R3
    qual_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R4
    qual_gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !clr) |=> (cnt == '0));
endmodule

// File: rtl/cdq_hold.sv
// Hold-off timer: loaded on carrier entry, reloaded by every active
// sample while running, and expiring on the HOLD_CYCLES-th quiet sample.
// Assumes: run is high only after a load.
module cdq_hold #(
    parameter int HOLD_CYCLES = 35795
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic run,
    input  logic act,
    output logic expire
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] FULL = HW'(HOLD_CYCLES);

    logic [HW-1:0] cnt;

    // Purpose: expiry on a quiet sample with one count left.
    assign expire = run && !act && (cnt == HW'(1));

    // Purpose: reload on entry or activity, count down on quiet samples.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)               cnt <= '0;
        else if (load || (run && act))   cnt <= FULL;
        else if (run && cnt != '0)       cnt <= cnt - 1'b1;
    end

    // R6
    hold_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |-> (cnt != '0));
endmodule

// File: rtl/cd_qualifier.sv
// Carrier detect qualifier. Synchronises the activity flag, declares a
// carrier after an unbroken qualification run, holds it through dropouts
// shorter than the hold-off, and releases after a full quiet hold-off.
// Assumes: pwdn is synchronous to clk; act_in may be asynchronous.
module cd_qualifier #(
    parameter int QUAL_CYCLES = 28636,
    parameter int HOLD_CYCLES = 35795,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_in,
    input  logic pwdn,
    output logic cd_n,
    output logic rx_gate
);
    import cdq_pkg::*;

    cdq_state_t state_q, state_d;
    logic act_s, qual_done, hold_expire, carrier;

    assign carrier = (state_q == CDQ_CARRIER);

    cdq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .clr(pwdn), .d(act_in), .q(act_s)
    );

    cdq_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk(clk), .rst_n(rst_n), .clr(pwdn || carrier),
        .act(act_s), .done(qual_done)
    );

    cdq_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(pwdn), .load(qual_done),
        .run(carrier), .act(act_s), .expire(hold_expire)
    );

    // Purpose: next decision from qualification, expiry and power-down.
    always_comb begin
        state_d = state_q;
        if (pwdn)                                    state_d = CDQ_IDLE;
        else if (state_q == CDQ_IDLE && qual_done)   state_d = CDQ_CARRIER;
        else if (carrier && hold_expire)             state_d = CDQ_IDLE;
    end

    // Purpose: decision register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CDQ_IDLE;
        else        state_q <= state_d;
    end

    assign cd_n    = !carrier;
    assign rx_gate = carrier;

    // R8
    pwdn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwdn |=> (cd_n && !rx_gate));

    // R3
    assert_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n) |-> ($past(act_s) && !$past(pwdn)));

    // R6
    hold_ride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cd_n && act_s && !pwdn) |=> !cd_n);

    // R7
    release_on_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_n) |-> ($past(pwdn) || !$past(act_s)));

    // R9
    wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwdn) |=> cd_n);
endmodule

// File: tb/tb_cd_qualifier.sv
module tb_cd_qualifier;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam int H = 10;
    localparam int DQ = 28636;
    localparam int DH = 35795;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_in = 1'b0;
    logic pwdn = 1'b0;
    logic cd_n, rx_gate, cd_def, gate_def;

    int vectors = 0, miscompares = 0;
    int n, low_cnt, first_low, gate_bad, win_lo, win_hi, win_hi_cnt;
    int fl_d, rl_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    cd_qualifier #(.QUAL_CYCLES(Q), .HOLD_CYCLES(H)) dut (
        .clk(clk), .rst_n(rst_n), .act_in(act_in), .pwdn(pwdn),
        .cd_n(cd_n), .rx_gate(rx_gate)
    );

    cd_qualifier dut_def (
        .clk(clk), .rst_n(rst_n), .act_in(act_in), .pwdn(pwdn),
        .cd_n(cd_def), .rx_gate(gate_def)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, pass one posedge, sample at the next negedge.
    task automatic cyc(input logic a);
        act_in = a;
        @(posedge clk);
        @(negedge clk);
        n++;
        if (rx_gate !== !cd_n) gate_bad++;
        if (cd_n === 1'b0) begin
            low_cnt++;
            if (first_low == 0) first_low = n;
        end
        if (n >= win_lo && n <= win_hi && cd_n === 1'b1) win_hi_cnt++;
        if (cd_def === 1'b0 && fl_d == 0) fl_d = n;
        if (cd_def === 1'b1 && fl_d != 0 && rl_d == 0) rl_d = n;
    endtask

    task automatic restart();
        rst_n = 1'b0; pwdn = 1'b0; act_in = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        // R2: reset state with activity present
        chk(cd_n === 1'b1, "R2 cd_n in reset", cd_n, 1);
        chk(rx_gate === 1'b0, "R2 rx_gate in reset", rx_gate, 0);
        rst_n = 1'b1; act_in = 1'b0;
        n = 0; low_cnt = 0; first_low = 0; gate_bad = 0;
        win_lo = -1; win_hi = -2; win_hi_cnt = 0; fl_d = 0; rl_d = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R3 R5 R7: burst length sweep across the qualification threshold
        for (int len = 1; len <= Q + 2; len++) begin
            restart();
            for (int i = 0; i < len; i++) cyc(1'b1);
            for (int i = 0; i < H + Q + 6; i++) cyc(1'b0);
            chk(low_cnt == ((len >= Q) ? len + H - Q : 0), "R3/R7 low cycles", low_cnt,
                (len >= Q) ? len + H - Q : 0);
            if (len >= Q)
                chk(first_low == Q + 2, "R5 assert latency", first_low, Q + 2);
            chk(gate_bad == 0, "R1 rx_gate vs cd_n", gate_bad, 0);
        end
        // R4: one-sample hole at every position of the qualification run
        for (int k = 1; k < Q; k++) begin
            restart();
            for (int i = 0; i < k; i++) cyc(1'b1);
            cyc(1'b0);
            for (int i = 0; i < Q; i++) cyc(1'b1);
            for (int i = 0; i < H + 4; i++) cyc(1'b0);
            chk(first_low == k + Q + 3, "R4 restart after hole", first_low, k + Q + 3);
        end
        // R6 R7: dropout gap sweep after a declared carrier
        for (int g = 1; g <= H + 1; g++) begin
            restart();
            win_lo = Q + 2; win_hi = Q + g + (Q + 4) + 2;
            for (int i = 0; i < Q; i++) cyc(1'b1);
            for (int i = 0; i < g; i++) cyc(1'b0);
            for (int i = 0; i < Q + 4; i++) cyc(1'b1);
            for (int i = 0; i < 4; i++) cyc(1'b0);
            chk(win_hi_cnt == ((g >= H) ? Q + g - H : 0), "R6/R7 gap ride or release",
                win_hi_cnt, (g >= H) ? Q + g - H : 0);
            chk(gate_bad == 0, "R1 rx_gate vs cd_n", gate_bad, 0);
        end
        // R8 R9: power-down with activity present, then wake
        restart();
        for (int i = 0; i < Q + 2; i++) cyc(1'b1);
        chk(cd_n === 1'b0, "R8 carrier before power-down", cd_n, 0);
        pwdn = 1'b1;
        win_lo = n + 1; win_hi = n + 5; win_hi_cnt = 0;
        for (int i = 0; i < 5; i++) cyc(1'b1);
        chk(win_hi_cnt == 5, "R8 idle in power-down", win_hi_cnt, 5);
        chk(rx_gate === 1'b0, "R8 gate in power-down", rx_gate, 0);
        pwdn = 1'b0;
        n = 0; first_low = 0; low_cnt = 0;
        for (int i = 0; i < Q + 4; i++) cyc(1'b1);
        chk(first_low == Q + 2, "R9 full requalify after wake", first_low, Q + 2);
        // R10: default windows
        restart();
        for (int i = 0; i < DQ + 4; i++) cyc(1'b1);
        for (int i = 0; i < DH + 4; i++) cyc(1'b0);
        chk(fl_d == DQ + 2, "R10 default qualify", fl_d, DQ + 2);
        chk(rl_d == DQ + 4 + DH + 2, "R10 default hold", rl_d, DQ + 4 + DH + 2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule